// File: doc/BRIEF.md
# Dual-Output Interrupt Controller

This block gathers a vector of level-sensitive interrupt lines and drives two request outputs toward a processor: a normal request and a fast request. Every line is sampled into a raw-level vector. Two independent enable masks sit over that single raw vector, one per output. Each output goes high whenever at least one raw bit is set and enabled for that output. Software changes a mask through a pair of word addresses: one ORs bits into the mask and the other knocks bits out. The mask itself is never written directly.

Source 0 is shared with a software interrupt. A latch that software sets and clears is ORed with input line 0, so firmware can raise a request on its own and test the whole interrupt path. The register port is word-indexed. It has separate read and write strobes. Read data is registered and appears one clock after the read strobe.

Top module: `dual_intc`

## Requirements
- R1: After synchronous reset, both enable masks and the software latch are zero, both request outputs are low, and read data is zero.
- R2: Reading index 1 or index 9 returns the raw vector. Bits 1 and up equal the source lines sampled one clock earlier. Bit 0 is that sampled line ORed with the software latch.
- R3: A write to index 2 ORs the write data into the normal-request enable mask. Reading index 2 returns that mask.
- R4: A write to index 3 clears every normal-request enable bit where the write data is 1 and leaves the other bits unchanged.
- R5: Indices 10 (OR into the mask) and 11 (clear where 1) manage the fast-request enable mask the same way, and reading index 10 returns it. Neither mask is affected by writes aimed at the other.
- R6: Reading index 0 returns raw AND normal-request mask. Reading index 8 returns raw AND fast-request mask.
- R7: A write to index 4 with data bit 0 set sets the software latch. A write to index 4 with bit 0 clear has no effect. Reading index 4 returns raw bit 0 in bit 0 and zero in all other bits.
- R8: A write to index 5 with data bit 0 set clears the software latch. Raw bit 0 then follows source line 0 alone.
- R9: Each request output is registered. It equals the OR-reduction of (raw AND its mask) as that value stood one clock earlier.
- R10: Reads of indices 3, 5, 11 and of any index outside {0,1,2,4,8,9,10} return zero. Writes to indices 0, 1, 8, 9 and to any index outside {2,3,4,5,10,11} change no state.
- R11: Read data changes only on the clock edge at which the read strobe is high. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt source lines |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Raw bit 0 is the hardest case to reach from the ports, because it has two owners. The test must separate a latch-only request, a line-only request, and a latch clear that happens while the line is still high. The stimulus does this by setting the latch with line 0 low and then clearing it. It then raises line 0 and clears the latch again, reading index 4 and watching the request output after each step. A second hard case is the one-cycle output lag. To cover it, the output is sampled both on the edge after a mask or source change and on the edge after that.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 4;

  // Register word indices; the offsets are part of the software contract.
  localparam logic [ADDR_W-1:0] RG_IRQ_PEND    = 4'd0;
  localparam logic [ADDR_W-1:0] RG_RAW         = 4'd1;
  localparam logic [ADDR_W-1:0] RG_IRQ_EN_SET  = 4'd2;
  localparam logic [ADDR_W-1:0] RG_IRQ_EN_CLR  = 4'd3;
  localparam logic [ADDR_W-1:0] RG_SW_SET      = 4'd4;
  localparam logic [ADDR_W-1:0] RG_SW_CLR      = 4'd5;
  localparam logic [ADDR_W-1:0] RG_FIQ_PEND    = 4'd8;
  localparam logic [ADDR_W-1:0] RG_RAW_ALT     = 4'd9;
  localparam logic [ADDR_W-1:0] RG_FIQ_EN_SET  = 4'd10;
  localparam logic [ADDR_W-1:0] RG_FIQ_EN_CLR  = 4'd11;

  typedef enum logic {PATH_IRQ = 1'b0, PATH_FIQ = 1'b1} path_e;
endpackage

// File: rtl/intc_raw_capture.sv
module intc_raw_capture #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               sw_set_i,
  input  logic               sw_clr_i,
  output logic [NUM_SRC-1:0] raw_o
);
  logic [NUM_SRC-1:0] src_q;
  logic               sw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      sw_q  <= 1'b0;
    end else begin
      src_q <= src_i;
      if (sw_set_i)      sw_q <= 1'b1;
      else if (sw_clr_i) sw_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (i == 0) begin : g_shared
      assign raw_o[i] = src_q[i] | sw_q;
    end else begin : g_line
      assign raw_o[i] = src_q[i];
    end
  end

  // R7
  sw_set_chk: assert property (@(posedge clk) disable iff (rst)
    sw_set_i |=> raw_o[0]);

  // R8
  sw_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_clr_i && !sw_set_i && !src_i[0]) |=> !raw_o[0]);
endmodule

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en_i,
  input  logic               clr_en_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] raw_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               hit_o
);
  logic [NUM_SRC-1:0] mask_q;
  logic               hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      if (set_en_i)      mask_q <= mask_q | wdata_i;
      else if (clr_en_i) mask_q <= mask_q & ~wdata_i;
      hit_q <= |(raw_i & mask_q);
    end
  end

  assign mask_o = mask_q;
  assign hit_o  = hit_q;

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_en_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en_i && !set_en_i) |=> ((mask_q & $past(wdata_i)) == '0));

  // R9
  hit_after_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((set_en_i && |(wdata_i & raw_i)) ##1 $stable(raw_i)) |=> hit_o);

  // R9
  hit_after_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en_i && !set_en_i && (&wdata_i)) |=> ##1 !hit_o);
endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] raw_i,
  input  logic [NUM_SRC-1:0] irq_mask_i,
  input  logic [NUM_SRC-1:0] fiq_mask_i,
  output logic [NUM_SRC-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      RG_IRQ_PEND:   rdata_o = raw_i & irq_mask_i;
      RG_RAW:        rdata_o = raw_i;
      RG_IRQ_EN_SET: rdata_o = irq_mask_i;
      RG_SW_SET:     rdata_o = {{(NUM_SRC-1){1'b0}}, raw_i[0]};
      RG_FIQ_PEND:   rdata_o = raw_i & fiq_mask_i;
      RG_RAW_ALT:    rdata_o = raw_i;
      RG_FIQ_EN_SET: rdata_o = fiq_mask_i;
      default:       rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dual_intc.sv
module dual_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_SRC-1:0]  bus_wdata,
  output logic [NUM_SRC-1:0]  bus_rdata,
  output logic                irq_o,
  output logic                fiq_o
);
  localparam int NUM_PATH = 2;

  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] mask [NUM_PATH];
  logic [NUM_PATH-1:0] hit;
  logic [NUM_PATH-1:0] set_en;
  logic [NUM_PATH-1:0] clr_en;
  logic               sw_set, sw_clr;
  logic [NUM_SRC-1:0] rd_mux;
  logic [NUM_SRC-1:0] rdata_q;

  assign set_en[PATH_IRQ] = bus_wr_en && (bus_addr == RG_IRQ_EN_SET);
  assign clr_en[PATH_IRQ] = bus_wr_en && (bus_addr == RG_IRQ_EN_CLR);
  assign set_en[PATH_FIQ] = bus_wr_en && (bus_addr == RG_FIQ_EN_SET);
  assign clr_en[PATH_FIQ] = bus_wr_en && (bus_addr == RG_FIQ_EN_CLR);
  assign sw_set = bus_wr_en && (bus_addr == RG_SW_SET) && bus_wdata[0];
  assign sw_clr = bus_wr_en && (bus_addr == RG_SW_CLR) && bus_wdata[0];

  intc_raw_capture #(.NUM_SRC(NUM_SRC)) u_raw (
    .clk      (clk),
    .rst      (rst),
    .src_i    (src_i),
    .sw_set_i (sw_set),
    .sw_clr_i (sw_clr),
    .raw_o    (raw)
  );

  for (genvar p = 0; p < NUM_PATH; p++) begin : g_path
    intc_mask_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .set_en_i (set_en[p]),
      .clr_en_i (clr_en[p]),
      .wdata_i  (bus_wdata),
      .raw_i    (raw),
      .mask_o   (mask[p]),
      .hit_o    (hit[p])
    );
  end

  intc_read_mux #(.NUM_SRC(NUM_SRC)) u_rmux (
    .addr_i     (bus_addr),
    .raw_i      (raw),
    .irq_mask_i (mask[PATH_IRQ]),
    .fiq_mask_i (mask[PATH_FIQ]),
    .rdata_o    (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst)            rdata_q <= '0;
    else if (bus_rd_en) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = hit[PATH_IRQ];
  assign fiq_o     = hit[PATH_FIQ];

  // R10
  ro_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && (bus_addr == RG_IRQ_PEND || bus_addr == RG_RAW ||
                   bus_addr == RG_FIQ_PEND || bus_addr == RG_RAW_ALT))
    |=> ($stable(mask[PATH_IRQ]) && $stable(mask[PATH_FIQ])));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> $stable(bus_rdata));

  // R5
  fiq_isolate_chk: assert property (@(posedge clk) disable iff (rst)
    (set_en[PATH_IRQ] || clr_en[PATH_IRQ]) |=> $stable(mask[PATH_FIQ]));
endmodule

// File: tb/dual_intc_test.sv
module dual_intc_test;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] src = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         irq, fiq;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dual_intc #(.NUM_SRC(N)) uut (
    .clk(clk), .rst(rst), .src_i(src),
    .bus_wr_en(wr_en), .bus_rd_en(rd_en), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_src(input logic [N-1:0] v);
    @(negedge clk);
    src = v;
    tick(2);
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic t_reset;
    logic [N-1:0] d;
    rst = 1'b1;
    tick(3);
    check("R1 irq_o in reset", {31'b0, irq}, '0);
    check("R1 fiq_o in reset", {31'b0, fiq}, '0);
    check("R1 rdata in reset", rdata, '0);
    rst = 1'b0;
    rd(4'd2, d);  check("R1 irq mask", d, '0);
    rd(4'd10, d); check("R1 fiq mask", d, '0);
    rd(4'd4, d);  check("R1 soft latch", d, '0);
  endtask

  task automatic t_raw;
    logic [N-1:0] d;
    set_src(32'hA5A5_0F0E);
    rd(4'd1, d); check("R2 raw idx1", d, 32'hA5A5_0F0E);
    rd(4'd9, d); check("R2 raw idx9", d, 32'hA5A5_0F0E);
    set_src(32'h5A5A_F0F0);
    rd(4'd1, d); check("R2 raw second pattern", d, 32'h5A5A_F0F0);
    set_src(32'hA5A5_0F0E);
  endtask

  task automatic t_irq_mask;
    logic [N-1:0] d;
    wr(4'd2, 32'h0000_00FF);
    wr(4'd2, 32'h0F00_0000);
    rd(4'd2, d); check("R3 irq set accumulates", d, 32'h0F00_00FF);
    wr(4'd3, 32'h0000_000F);
    rd(4'd2, d); check("R4 irq clear", d, 32'h0F00_00F0);
  endtask

  task automatic t_fiq_mask;
    logic [N-1:0] d;
    wr(4'd10, 32'hF000_0000);
    rd(4'd10, d); check("R5 fiq set", d, 32'hF000_0000);
    rd(4'd2, d);  check("R5 irq untouched by fiq set", d, 32'h0F00_00F0);
    wr(4'd11, 32'hFFFF_FFFF);
    rd(4'd10, d); check("R5 fiq clear", d, '0);
    rd(4'd2, d);  check("R5 irq untouched by fiq clear", d, 32'h0F00_00F0);
  endtask

  task automatic t_status;
    logic [N-1:0] d;
    wr(4'd10, 32'h0000_0F00);
    rd(4'd0, d); check("R6 irq status", d, 32'hA5A5_0F0E & 32'h0F00_00F0);
    rd(4'd8, d); check("R6 fiq status", d, 32'hA5A5_0F0E & 32'h0000_0F00);
    check("R9 irq_o high", {31'b0, irq}, 32'd1);
    check("R9 fiq_o high", {31'b0, fiq}, 32'd1);
  endtask

  task automatic t_outputs;
    wr(4'd3, 32'hFFFF_FFFF);
    check("R9 irq_o lags mask clear", {31'b0, irq}, 32'd1);
    tick(1);
    check("R9 irq_o low after clear", {31'b0, irq}, '0);
    wr(4'd2, 32'h0010_0000);
    tick(1);
    check("R9 irq_o low, source idle", {31'b0, irq}, '0);
    @(negedge clk);
    src = src | 32'h0010_0000;
    tick(1);
    check("R9 irq_o not yet after source", {31'b0, irq}, '0);
    tick(1);
    check("R9 irq_o after source", {31'b0, irq}, 32'd1);
    wr(4'd11, 32'hFFFF_FFFF);
    tick(1);
    check("R9 fiq_o low after clear", {31'b0, fiq}, '0);
    @(negedge clk);
    src = 32'hA5A5_0F0E;
    tick(2);
  endtask

  task automatic t_soft;
    logic [N-1:0] d;
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd4, d); check("R7 idx4 idle", d, '0);
    wr(4'd4, 32'h0000_0002);
    rd(4'd4, d); check("R7 set without bit0 ignored", d, '0);
    wr(4'd4, 32'h0000_0001);
    rd(4'd4, d); check("R7 soft set read", d, 32'd1);
    rd(4'd1, d); check("R7 raw bit0 from latch", d, 32'hA5A5_0F0F);
    wr(4'd2, 32'h0000_0001);
    tick(1);
    check("R7 irq_o from soft", {31'b0, irq}, 32'd1);
    wr(4'd5, 32'h0000_0000);
    rd(4'd4, d); check("R8 clear without bit0 ignored", d, 32'd1);
    wr(4'd5, 32'h0000_0001);
    rd(4'd4, d); check("R8 soft clear", d, '0);
    tick(1);
    check("R8 irq_o after soft clear", {31'b0, irq}, '0);
    set_src(32'hA5A5_0F0F);
    wr(4'd5, 32'h0000_0001);
    rd(4'd4, d); check("R8 line still drives bit0", d, 32'd1);
    check("R8 irq_o from line", {31'b0, irq}, 32'd1);
    set_src(32'hA5A5_0F0E);
  endtask

  task automatic t_wrong_dir;
    logic [N-1:0] d;
    wr(4'd2, 32'h00FF_FF00);
    wr(4'd10, 32'h0F0F_0000);
    rd(4'd3, d);  check("R10 read idx3", d, '0);
    rd(4'd5, d);  check("R10 read idx5", d, '0);
    rd(4'd11, d); check("R10 read idx11", d, '0);
    rd(4'd6, d);  check("R10 read idx6", d, '0);
    rd(4'd15, d); check("R10 read idx15", d, '0);
    for (int i = 0; i < 16; i++) begin
      if (i == 0 || i == 1 || i == 7 || i == 8 || i == 9 || i == 12)
        wr(4'(i), 32'hFFFF_FFFF);
    end
    rd(4'd2, d);  check("R10 irq mask unchanged", d, 32'h00FF_FF01);
    rd(4'd10, d); check("R10 fiq mask unchanged", d, 32'h0F0F_0000);
    rd(4'd4, d);  check("R10 soft latch unchanged", d, '0);
    rd(4'd1, d);  check("R11 last read value", d, 32'hA5A5_0F0E);
    set_src(32'h1234_5678);
    tick(3);
    check("R11 rdata held without read", rdata, 32'hA5A5_0F0E);
  endtask

  initial begin
    t_reset();
    t_raw();
    t_irq_mask();
    t_fiq_mask();
    t_status();
    t_outputs();
    t_soft();
    t_wrong_dir();
    tick(2);
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end
endmodule